// File: doc/BRIEF.md
# Clock Configuration I2C Slave

This block is the serial configuration port of a clock generator. It watches a standard two-wire bus (SCL and SDA), oversampled by a faster system clock, and keeps eight 8-bit configuration registers. The registers set the frequency source and code, spread-spectrum and output tristate controls, the enable bit of every clock output, and a general control byte. One register also shows the frequency straps latched after reset, and the last is a fixed identification byte.

The protocol has no register addressing. A write names the device with byte 0xD2, then sends a command byte and a count byte. The slave acknowledges both and throws their contents away. Every data byte after that lands in the next register, starting at register 0. A read uses byte 0xD3. The slave returns a count of 8 and then all eight registers in order, for as long as the controller acknowledges. The slave only ever pulls SDA low.

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low during the ninth clock.
- R2: After any other address byte the slave does not acknowledge, stays idle, and ignores every byte until the next start condition. No register changes.
- R3: In a write, the slave acknowledges the first two bytes after the address and discards them. Each following data byte is acknowledged and written to registers 0, 1, 2 and so on. Bytes after the eighth do nothing.
- R4: A write that stops after N complete data bytes leaves registers N and above unchanged.
- R5: A read returns the byte 8 first, then registers 0 to 7. The slave sends the next byte only after the controller acknowledges, and it goes idle on a not-acknowledge.
- R6: Register 0 resets to 0x00. Bit 1 drives spread_en_o and bit 0 drives tristate_o. When bit 3 is 1, freq_sel_o = {bit 2, bits 7:4}. When bit 3 is 0, freq_sel_o = {0, latched strap}.
- R7: Registers 1 to 4 reset to 0xFF and the low nibble of register 5 resets to 0xF. out_en_o = {reg5[3:0], reg4, reg3, reg2, reg1}, so out_en_o[0] is bit 0 of register 1.
- R8: Register 5 bits 7:4 read back the inverse of strap_fs_i as captured in the first clock after reset. Writes to these bits are ignored.
- R9: Register 7 always reads 0x28, and writes to it are ignored.
- R10: A start or stop condition in the middle of a byte aborts the transfer and discards the partial byte. A repeated start begins a new address phase.
- R11: SDA is only pulled low and is released otherwise. The pull changes only while SCL is low.
- R12: Register 6 resets to 0x01, is fully writable and drives ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_fs_i | input | 4 | Frequency strap pins, latched after reset |
| freq_sel_o | output | 5 | Effective frequency-select code |
| spread_en_o | output | 1 | Spread-spectrum enable |
| tristate_o | output | 1 | Tristate all clock outputs |
| out_en_o | output | 36 | Per-output enables, 0 holds the output low |
| ctrl_o | output | 8 | General control byte (register 6) |

## Verification
The bench attacks byte-boundary handling. A write cut short after one or three bytes catches a slave that clears or shifts registers it never reached. A stop or repeated start after a few bits of a data byte catches a design that commits partial bytes. Writes that aim at the strap nibble and the identification byte would show up in the read-back if the read-only bits were stored. A read ended early by a not-acknowledge, and an unknown address followed by extra bytes, expose a slave that keeps driving SDA or wakes up without a new start.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;

   localparam int NUM_REGS  = 8;
   localparam int STRAP_REG = 5;
   localparam int ID_REG    = 7;
   localparam int STRAP_W   = 4;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RX,
      S_ACK,
      S_TX,
      S_MACK
   } eng_state_t;

   typedef enum logic [1:0] {
      P_ADDR,
      P_CMD,
      P_CNT,
      P_DATA
   } rx_phase_t;

   function automatic logic [7:0] reg_reset(input int idx);
      case (idx)
         0:       return 8'h00;
         1, 2, 3, 4: return 8'hFF;
         5:       return 8'h0F;
         6:       return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/clkcfg_sync.sv
module clkcfg_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("clkcfg_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
   import clkcfg_pkg::*;
#(
   parameter logic [7:0] ID_VALUE = 8'h28,
   parameter int         IDX_W    = $clog2(NUM_REGS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [STRAP_W-1:0]        strap_i,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [7:0]                wr_data,
   input  logic [IDX_W-1:0]          rd_idx,
   output logic [7:0]                rd_data,
   output logic [ID_REG*8-1:0]       cfg_o
);
   logic [7:0]         view [NUM_REGS];
   logic [STRAP_W-1:0] strap_q;
   logic               strap_done;

   // captures the straps once, in the first clock after reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_q    <= '0;
         strap_done <= 1'b0;
      end else if (!strap_done) begin
         strap_q    <= ~strap_i;
         strap_done <= 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         localparam logic [7:0] RST = reg_reset(g);
         if (g == ID_REG) begin : g_id
            assign view[g] = ID_VALUE;
         end else if (g == STRAP_REG) begin : g_strap
            logic [7-STRAP_W:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= RST[7-STRAP_W:0];
               else if (wr_en && wr_idx == IDX_W'(g))
                  q <= wr_data[7-STRAP_W:0];
            end
            assign view[g] = {strap_q, q};
         end else begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  q <= RST;
               else if (wr_en && wr_idx == IDX_W'(g))
                  q <= wr_data;
            end
            assign view[g] = q;
         end
         if (g < ID_REG) begin : g_out
            assign cfg_o[g*8 +: 8] = view[g];
         end
      end
   endgenerate

   assign rd_data = view[rd_idx];
endmodule

// File: rtl/clkcfg_i2c_engine.sv
module clkcfg_i2c_engine
   import clkcfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR7 = 7'h69,
   parameter int         IDX_W     = $clog2(NUM_REGS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl,
   input  logic             sda,
   output logic             sda_pull,
   output logic             busy,
   output logic             wr_en,
   output logic [IDX_W-1:0] wr_idx,
   output logic [7:0]       wr_data,
   output logic [IDX_W-1:0] rd_idx,
   input  logic [7:0]       rd_data
);
   localparam int CNT_W = $clog2(NUM_REGS + 2);

   eng_state_t       state;
   rx_phase_t        phase;
   logic             scl_q, sda_q;
   logic             is_read, mack;
   logic [3:0]       bcnt;
   logic [7:0]       shreg, tx_byte;
   logic [CNT_W-1:0] widx, tidx;

   wire scl_rise = scl & ~scl_q;
   wire scl_fall = ~scl & scl_q;
   wire start_c  = scl & scl_q & sda_q & ~sda;
   wire stop_c   = scl & scl_q & ~sda_q & sda;

   assign rd_idx = IDX_W'(tidx - CNT_W'(1));
   assign busy   = (state != S_IDLE);

   always_comb begin
      if (tidx == '0)                       tx_byte = 8'(NUM_REGS);
      else if (tidx <= CNT_W'(NUM_REGS))    tx_byte = rd_data;
      else                                  tx_byte = 8'hFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         phase    <= P_ADDR;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         is_read  <= 1'b0;
         mack     <= 1'b1;
         bcnt     <= '0;
         shreg    <= '0;
         widx     <= '0;
         tidx     <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
         wr_en <= 1'b0;
         if (start_c) begin
            state    <= S_RX;
            phase    <= P_ADDR;
            bcnt     <= '0;
            sda_pull <= 1'b0;
         end else if (stop_c) begin
            state    <= S_IDLE;
            sda_pull <= 1'b0;
         end else begin
            case (state)
               S_RX: begin
                  if (scl_rise && bcnt != 4'd8) begin
                     shreg <= {shreg[6:0], sda};
                     bcnt  <= bcnt + 4'd1;
                  end else if (scl_fall && bcnt == 4'd8) begin
                     bcnt <= '0;
                     case (phase)
                        P_ADDR: begin
                           if (shreg[7:1] == DEV_ADDR7) begin
                              is_read  <= shreg[0];
                              phase    <= P_CMD;
                              widx     <= '0;
                              tidx     <= '0;
                              sda_pull <= 1'b1;
                              state    <= S_ACK;
                           end else begin
                              state <= S_IDLE;
                           end
                        end
                        P_CMD: begin
                           phase    <= P_CNT;
                           sda_pull <= 1'b1;
                           state    <= S_ACK;
                        end
                        P_CNT: begin
                           phase    <= P_DATA;
                           sda_pull <= 1'b1;
                           state    <= S_ACK;
                        end
                        default: begin
                           sda_pull <= 1'b1;
                           state    <= S_ACK;
                           if (widx < CNT_W'(NUM_REGS)) begin
                              wr_en   <= 1'b1;
                              wr_idx  <= IDX_W'(widx);
                              wr_data <= shreg;
                              widx    <= widx + CNT_W'(1);
                           end
                        end
                     endcase
                  end
               end
               S_ACK: begin
                  if (scl_fall) begin
                     if (is_read) begin
                        shreg    <= tx_byte;
                        tidx     <= tidx + CNT_W'(1);
                        sda_pull <= ~tx_byte[7];
                        bcnt     <= '0;
                        state    <= S_TX;
                     end else begin
                        sda_pull <= 1'b0;
                        state    <= S_RX;
                     end
                  end
               end
               S_TX: begin
                  if (scl_fall) begin
                     if (bcnt == 4'd7) begin
                        sda_pull <= 1'b0;
                        state    <= S_MACK;
                     end else begin
                        shreg    <= {shreg[6:0], 1'b1};
                        sda_pull <= ~shreg[6];
                        bcnt     <= bcnt + 4'd1;
                     end
                  end
               end
               S_MACK: begin
                  if (scl_rise) begin
                     mack <= sda;
                  end else if (scl_fall) begin
                     if (!mack) begin
                        shreg    <= tx_byte;
                        tidx     <= tidx + CNT_W'(1);
                        sda_pull <= ~tx_byte[7];
                        bcnt     <= '0;
                        state    <= S_TX;
                     end else begin
                        state <= S_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
   import clkcfg_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR7   = 7'h69,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] ID_VALUE    = 8'h28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         scl_i,
   input  logic         sda_i,
   output logic         sda_pull_o,
   input  logic [3:0]   strap_fs_i,
   output logic [4:0]   freq_sel_o,
   output logic         spread_en_o,
   output logic         tristate_o,
   output logic [35:0]  out_en_o,
   output logic [7:0]   ctrl_o
);
   localparam int IDX_W = $clog2(NUM_REGS);

   generate
      if (DEV_ADDR7 == 7'h00) begin : g_bad_addr
         $error("device address must not be the general-call address");
      end
      if (NUM_REGS != 8 || STRAP_W != 4) begin : g_bad_map
         $error("output mapping assumes eight registers and four straps");
      end
   endgenerate

   logic               scl_s, sda_s, eng_busy, wr_en;
   logic [IDX_W-1:0]   wr_idx, rd_idx;
   logic [7:0]         wr_data, rd_data;
   logic [ID_REG*8-1:0] cfg;

   clkcfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
   clkcfg_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

   clkcfg_i2c_engine #(.DEV_ADDR7(DEV_ADDR7), .IDX_W(IDX_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s),
      .sda_pull(sda_pull_o), .busy(eng_busy),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data));

   clkcfg_regbank #(.ID_VALUE(ID_VALUE), .IDX_W(IDX_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_fs_i),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_idx(rd_idx), .rd_data(rd_data), .cfg_o(cfg));

   // register 0 fields
   assign spread_en_o = cfg[1];
   assign tristate_o  = cfg[0];
   assign freq_sel_o  = cfg[3] ? {cfg[2], cfg[7:4]} : {1'b0, ~cfg[STRAP_REG*8+4 +: 4]};
   // enables: registers 1..4 whole, register 5 low nibble
   assign out_en_o    = {cfg[STRAP_REG*8 +: 4], cfg[8 +: 32]};
   assign ctrl_o      = cfg[6*8 +: 8];
endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker #(
   parameter int         IDX_W    = 3,
   parameter int         ID_IDX   = 7,
   parameter logic [7:0] ID_VALUE = 8'h28
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_s,
   input logic             sda_pull,
   input logic             busy,
   input logic             wr_en,
   input logic [IDX_W-1:0] rd_idx,
   input logic [7:0]       rd_data,
   input logic [7:0]       reg0_q
);
   AST_IDLE_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sda_pull); // R2

   AST_WRITE_INSIDE_TRANSFER: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy); // R3

   AST_REG0_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_en) |-> $stable(reg0_q)); // R4

   AST_ID_BYTE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx == IDX_W'(ID_IDX)) |-> (rd_data == ID_VALUE)); // R9

   AST_SDA_STILL_WHILE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s)) |-> $stable(sda_pull)); // R11
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(
   .IDX_W(IDX_W), .ID_IDX(7), .ID_VALUE(ID_VALUE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_pull(sda_pull_o),
   .busy(eng_busy), .wr_en(wr_en), .rd_idx(rd_idx), .rd_data(rd_data),
   .reg0_q(cfg[7:0])
);

// File: tb/clkcfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module clkcfg_i2c_slave_tb;
   localparam int Q  = 10;
   localparam int NV = 5;
   localparam logic [67:0] VEC [NV] = '{
      {4'd8, 64'h77_66_FA_44_33_22_11_3A},
      {4'd1, 64'h00_00_00_00_00_00_00_09},
      {4'd3, 64'h00_00_00_00_00_C3_00_F4},
      {4'd0, 64'h00_00_00_00_00_00_00_00},
      {4'd7, 64'h00_80_05_5A_A5_01_FE_C6}
   };

   logic clk = 0, rst_n = 0;
   logic m_scl = 1, m_pull = 0;
   logic [3:0] strap = 4'b1010;
   logic sda_pull_o, spread_en_o, tristate_o;
   logic [4:0] freq_sel_o;
   logic [35:0] out_en_o;
   logic [7:0] ctrl_o;
   wire sda_bus = ~(m_pull | sda_pull_o);

   int n_chk = 0, n_bad = 0;
   logic [7:0] expr [8];
   logic [7:0] rb [9];
   logic ack;

   always #2 clk = ~clk;

   clkcfg_i2c_slave u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
      .sda_pull_o(sda_pull_o), .strap_fs_i(strap), .freq_sel_o(freq_sel_o),
      .spread_en_o(spread_en_o), .tristate_o(tristate_o),
      .out_en_o(out_en_o), .ctrl_o(ctrl_o));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      m_pull = 0; wq(); m_scl = 1; wq(); m_pull = 1; wq(); m_scl = 0; wq();
   endtask

   task automatic bus_stop();
      m_pull = 1; wq(); m_scl = 1; wq(); m_pull = 0; wq(); wq();
   endtask

   task automatic send_bit(input logic b);
      m_pull = ~b; wq(); m_scl = 1; wq(); wq(); m_scl = 0; wq();
   endtask

   task automatic recv_bit(output logic b);
      m_pull = 0; wq(); m_scl = 1; wq(); b = sda_bus; wq(); m_scl = 0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic a);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(d[i]);
      recv_bit(b);
      a = ~b;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] d);
      for (int i = 7; i >= 0; i--) recv_bit(d[i]);
      send_bit(~give_ack);
   endtask

   task automatic do_write(input int n, input logic [63:0] data);
      bus_start();
      send_byte(8'hD2, ack); chk("R1 write address ack", ack, 1);
      send_byte(8'h5A, ack); chk("R3 command ack", ack, 1);
      send_byte(8'hA5, ack); chk("R3 count ack", ack, 1);
      for (int i = 0; i < n; i++) begin
         send_byte(data[8*i +: 8], ack);
         chk("R3 data ack", ack, 1);
         if (i == 5)      expr[5][3:0] = data[8*i +: 4];
         else if (i != 7) expr[i] = data[8*i +: 8];
      end
      bus_stop();
   endtask

   task automatic do_read(input int n);
      bus_start();
      send_byte(8'hD3, ack); chk("R1 read address ack", ack, 1);
      for (int i = 0; i < n; i++) recv_byte(i < n - 1, rb[i]);
      bus_stop();
   endtask

   task automatic check_ports(input string tag);
      logic [4:0] fs;
      fs = expr[0][3] ? {expr[0][2], expr[0][7:4]} : {1'b0, strap};
      chk({tag, " R6 freq_sel"}, freq_sel_o, fs);
      chk({tag, " R6 spread"}, spread_en_o, expr[0][1]);
      chk({tag, " R6 tristate"}, tristate_o, expr[0][0]);
      chk({tag, " R7 out_en"}, out_en_o,
          {expr[5][3:0], expr[4], expr[3], expr[2], expr[1]});
      chk({tag, " R12 ctrl"}, ctrl_o, expr[6]);
   endtask

   task automatic check_readback(input string tag);
      do_read(9);
      chk({tag, " R5 count byte"}, rb[0], 8'd8);
      for (int i = 0; i < 8; i++)
         chk({tag, (i == 5) ? " R8 reg5" : (i == 7) ? " R9 id" : " R5 reg"},
             rb[i+1], expr[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      expr = '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h5F, 8'h01, 8'h28};
      repeat (10) @(posedge clk);
      #1 rst_n = 1;
      repeat (5) @(posedge clk);
      #1;
      // reset state
      chk("R11 sda released at reset", sda_pull_o, 0);
      check_ports("reset");
      check_readback("reset");

      // vector table: write, then compare ports and read-back
      for (int v = 0; v < NV; v++) begin
         do_write(int'(VEC[v][67:64]), VEC[v][63:0]);
         check_ports("vector");
         check_readback("vector");
      end

      // R2: foreign address, then bytes that would be data
      bus_start();
      send_byte(8'hA0, ack); chk("R2 foreign address nack", ack, 0);
      send_byte(8'h5A, ack); chk("R2 idle after nack", ack, 0);
      send_byte(8'h00, ack); chk("R2 still idle", ack, 0);
      send_byte(8'h00, ack);
      bus_stop();
      chk("R11 sda released after nack", sda_pull_o, 0);
      check_readback("R2");

      // R5: early not-acknowledge ends the read
      do_read(3);
      chk("R5 short read count", rb[0], 8'd8);
      chk("R5 short read reg0", rb[1], expr[0]);
      chk("R5 short read reg1", rb[2], expr[1]);
      chk("R5 released after nack", sda_pull_o, 0);

      // R10: stop inside a data byte
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      for (int i = 0; i < 4; i++) send_bit(1'b0);
      bus_stop();
      check_ports("R10 stop abort");

      // R10: repeated start inside a data byte, then a fresh write
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      for (int i = 0; i < 3; i++) send_bit(1'b1);
      bus_start();
      send_byte(8'hD2, ack); chk("R10 address after restart", ack, 1);
      send_byte(8'h11, ack); send_byte(8'h22, ack);
      send_byte(8'h5C, ack);
      bus_stop();
      expr[0] = 8'h5C;
      check_ports("R10 restart");
      check_readback("R10 restart");

      // R3: bytes past the eighth are ignored
      do_write(8, 64'h00_AB_03_12_34_56_78_00);
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      for (int i = 0; i < 8; i++) send_byte(expr[i], ack);
      send_byte(8'hEE, ack); chk("R3 ninth byte acked", ack, 1);
      bus_stop();
      check_readback("R3 overflow");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule